// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block comes out of reset and reads the whole contents of a small three-wire serial EEPROM. It drives chip select, the serial clock and a serial data-out line, and it samples a serial data-in line. Each word takes its own transaction. Chip select rises and a 9-bit read command is shifted out: a start bit of 1, then an opcode byte that carries the word address. Sixteen data bits are then clocked back, MSB first. Chip select falls and stays low for a settle interval before the next word starts.

Every word goes into an internal image buffer and into a 16-bit running sum. After the last word the block compares the sum with a fixed signature. On a match it publishes three configuration fields taken from fixed byte offsets of the image and raises a valid flag. On a mismatch the fields keep safe defaults. A one-cycle done pulse marks the end of loading. The block then stays idle until the next reset, which starts the whole load again from the first word.

Top module: `cfg_prom_loader`

## Requirements
- R1: During and straight after reset, prom_cs, prom_sk, prom_do, load_done, cfg_valid and cfg_active_neg are 0, cfg_bus_id is 7 and cfg_tag_depth is 0.
- R2: One load makes exactly 64 chip-select transactions. Each has exactly 25 rising edges of prom_sk: 9 for the command, then 16 for data. prom_sk never goes high while prom_cs is low.
- R3: The transaction for word n (n = 0..63, in increasing order) shifts out the 9-bit command {1'b1, 8'h80 + n}, MSB first. prom_do is set up before each rising edge of prom_sk and holds steady while prom_sk is high.
- R4: Every high pulse of prom_sk lasts exactly SETTLE_CLKS clock cycles. prom_cs stays low for at least SETTLE_CLKS cycles before each transaction.
- R5: prom_di is sampled in the last cycle of each data high pulse. The first sampled bit is bit 15 of the word and the last is bit 0.
- R6: load_done is high for exactly one cycle per load, after the last word. After it, prom_cs and prom_sk stay low until the next reset.
- R7: cfg_valid is set together with load_done exactly when the 16-bit wraparound sum of the 64 words equals 16'h1234. It then holds its value until reset.
- R8: When valid, cfg_bus_id is image byte 0x40. Bytes are numbered two per word with the even byte as the low half, so this is bits [7:0] of word 32.
- R9: When valid, cfg_tag_depth is 2 shifted left by image byte 0x43 (bits [15:8] of word 33), truncated to DEPTH_W bits, so an exponent of 31 or more at DEPTH_W = 32 gives 0.
- R10: When valid, cfg_active_neg is bit 3 of image byte 0x41, which is bit 11 of word 32.
- R11: When the sum does not match, cfg_bus_id stays 7, cfg_tag_depth stays 0 and cfg_active_neg stays 0.
- R12: A reset during a load abandons it. The next load starts again at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts a new load when released |
| prom_cs | output | 1 | EEPROM chip select, active high |
| prom_sk | output | 1 | EEPROM serial clock |
| prom_do | output | 1 | Command bits to the EEPROM |
| prom_di | input | 1 | Data bits from the EEPROM |
| load_done | output | 1 | One-cycle pulse when loading ends |
| cfg_valid | output | 1 | Image checksum matched the signature |
| cfg_bus_id | output | 8 | Adapter bus ID, or 7 when the image is invalid |
| cfg_tag_depth | output | DEPTH_W | Tag depth, 2 << exponent |
| cfg_active_neg | output | 1 | Active negation enable |

## Verification
The bench aims at the sum comparison from both sides: it builds images that hit 16'h1234 exactly after wrapping and images that miss it by one. A design that fails to wrap the sum, or that sums only part of the image, gets cfg_valid wrong on one side. It feeds bus IDs and data words whose bit patterns are not symmetric, so a word clocked in LSB first or a swap of the high and low bytes shows up as a wrong field. It drives the tag exponent to 0, 30 and 31 to catch a shift that saturates or is cut short, and it resets in the middle of a load to catch a command counter that carries on from the word it had reached.

// File: rtl/prom_loader_pkg.sv
package prom_loader_pkg;

   // Sequencer phases; every phase except END and HALT advances on a tick.
   typedef enum logic [3:0] {
      ST_GAP,   // chip select low, settle
      ST_SEL,   // chip select high, settle
      ST_CSET,  // command bit set up on data-out
      ST_CHI,   // command clock high
      ST_CLO,   // command clock low
      ST_DHI,   // data clock high, sample at its end
      ST_DLO,   // data clock low
      ST_END,   // emit finish strobe
      ST_HALT   // idle until reset
   } seq_state_t;

   function automatic logic [7:0] byte_pick(input logic [15:0] w, input logic hi);
      return hi ? w[15:8] : w[7:0];
   endfunction

   function automatic logic byte_bit(input logic [15:0] w, input logic hi, input int pos);
      logic [7:0] b;
      b = byte_pick(w, hi);
      return b[pos];
   endfunction

endpackage

// File: rtl/prom_tick_gen.sv
module prom_tick_gen #(
   parameter int unsigned SETTLE_CLKS = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   localparam int unsigned CNT_W = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1;

   generate
      if (SETTLE_CLKS == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CLKS - 1);
         logic [CNT_W-1:0] cnt_q;
         assign tick = en && (cnt_q == CNT_LAST);
         always_ff @(posedge clk) begin
            if (rst)     cnt_q <= '0;
            else if (en) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/prom_word_reader.sv
module prom_word_reader
   import prom_loader_pkg::*;
#(
   parameter int unsigned WORD_CNT = 64,
   parameter int unsigned WORD_W   = 16,
   parameter logic [7:0]  CMD_BASE = 8'h80,
   localparam int unsigned IDX_W   = $clog2(WORD_CNT)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   output logic              run,
   output logic              prom_cs,
   output logic              prom_sk,
   output logic              prom_do,
   input  logic              prom_di,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [WORD_W-1:0] wr_data,
   output logic              finish
);
   localparam int unsigned CMD_W = 9;
   localparam int unsigned BIT_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_CNT - 1);

   seq_state_t        st_q;
   logic [BIT_W-1:0]  bit_q;
   logic [IDX_W-1:0]  word_q;
   logic [WORD_W-1:0] shr_q;
   logic [CMD_W-1:0]  cmd_word;

   assign cmd_word = {1'b1, CMD_BASE + 8'(word_q)};
   assign run      = (st_q != ST_END) && (st_q != ST_HALT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_GAP;
         bit_q   <= '0;
         word_q  <= '0;
         shr_q   <= '0;
         prom_cs <= 1'b0;
         prom_sk <= 1'b0;
         prom_do <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
         finish  <= 1'b0;
      end else begin
         wr_en  <= 1'b0;
         finish <= 1'b0;
         if (st_q == ST_END) begin
            finish <= 1'b1;
            st_q   <= ST_HALT;
         end else if (run && tick) begin
            unique case (st_q)
               ST_GAP: begin
                  prom_cs <= 1'b1;
                  st_q    <= ST_SEL;
               end
               ST_SEL: begin
                  prom_do <= cmd_word[CMD_W-1];
                  bit_q   <= BIT_W'(CMD_W - 1);
                  st_q    <= ST_CSET;
               end
               ST_CSET: begin
                  prom_sk <= 1'b1;
                  st_q    <= ST_CHI;
               end
               ST_CHI: begin
                  prom_sk <= 1'b0;
                  st_q    <= ST_CLO;
               end
               ST_CLO: begin
                  if (bit_q == '0) begin
                     prom_do <= 1'b0;
                     prom_sk <= 1'b1;
                     bit_q   <= BIT_W'(WORD_W - 1);
                     st_q    <= ST_DHI;
                  end else begin
                     prom_do <= cmd_word[bit_q - 1'b1];
                     bit_q   <= bit_q - 1'b1;
                     st_q    <= ST_CSET;
                  end
               end
               ST_DHI: begin
                  shr_q   <= {shr_q[WORD_W-2:0], prom_di};
                  prom_sk <= 1'b0;
                  st_q    <= ST_DLO;
               end
               ST_DLO: begin
                  if (bit_q == '0) begin
                     wr_en   <= 1'b1;
                     wr_idx  <= word_q;
                     wr_data <= shr_q;
                     prom_cs <= 1'b0;
                     if (word_q == LAST_IDX) begin
                        st_q <= ST_END;
                     end else begin
                        word_q <= word_q + 1'b1;
                        st_q   <= ST_GAP;
                     end
                  end else begin
                     bit_q   <= bit_q - 1'b1;
                     prom_sk <= 1'b1;
                     st_q    <= ST_DHI;
                  end
               end
               default: st_q <= ST_HALT;
            endcase
         end
      end
   end
endmodule

// File: rtl/prom_image_store.sv
module prom_image_store
   import prom_loader_pkg::*;
#(
   parameter int unsigned WORD_CNT   = 64,
   parameter int unsigned WORD_W     = 16,
   parameter logic [15:0] SIGNATURE  = 16'h1234,
   parameter int unsigned ID_BYTE    = 'h40,
   parameter int unsigned MODE_BYTE  = 'h41,
   parameter int unsigned TAG_BYTE   = 'h43,
   parameter int unsigned NEG_BIT    = 3,
   parameter logic [7:0]  DEF_BUS_ID = 8'd7,
   parameter int unsigned DEPTH_W    = 32,
   parameter bit          KEEP_IMAGE = 1'b1,
   localparam int unsigned IDX_W     = $clog2(WORD_CNT)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               finish,
   output logic               done,
   output logic               valid,
   output logic [7:0]         bus_id,
   output logic [DEPTH_W-1:0] tag_depth,
   output logic               active_neg
);
   localparam logic [IDX_W-1:0] ID_WORD   = IDX_W'(ID_BYTE / 2);
   localparam logic [IDX_W-1:0] MODE_WORD = IDX_W'(MODE_BYTE / 2);
   localparam logic [IDX_W-1:0] TAG_WORD  = IDX_W'(TAG_BYTE / 2);
   localparam logic ID_HI   = 1'(ID_BYTE % 2);
   localparam logic MODE_HI = 1'(MODE_BYTE % 2);
   localparam logic TAG_HI  = 1'(TAG_BYTE % 2);
   localparam logic [DEPTH_W-1:0] DEPTH_BASE = DEPTH_W'(2);

   logic [WORD_W-1:0] sum_q;
   logic [WORD_W-1:0] id_word, mode_word, tag_word;
   logic              sum_ok;

   generate
      if (KEEP_IMAGE) begin : g_full
         logic [WORD_W-1:0] img_q [WORD_CNT];
         always_ff @(posedge clk) begin
            if (wr_en) img_q[wr_idx] <= wr_data;
         end
         assign id_word   = img_q[ID_WORD];
         assign mode_word = img_q[MODE_WORD];
         assign tag_word  = img_q[TAG_WORD];
      end else begin : g_pick
         logic [WORD_W-1:0] id_q, mode_q, tag_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               id_q   <= '0;
               mode_q <= '0;
               tag_q  <= '0;
            end else if (wr_en) begin
               if (wr_idx == ID_WORD)   id_q   <= wr_data;
               if (wr_idx == MODE_WORD) mode_q <= wr_data;
               if (wr_idx == TAG_WORD)  tag_q  <= wr_data;
            end
         end
         assign id_word   = id_q;
         assign mode_word = mode_q;
         assign tag_word  = tag_q;
      end
   endgenerate

   assign sum_ok = (sum_q == SIGNATURE);

   always_ff @(posedge clk) begin
      if (rst) begin
         sum_q      <= '0;
         done       <= 1'b0;
         valid      <= 1'b0;
         bus_id     <= DEF_BUS_ID;
         tag_depth  <= '0;
         active_neg <= 1'b0;
      end else begin
         done <= finish;
         if (wr_en) sum_q <= sum_q + wr_data;
         if (finish) begin
            valid <= sum_ok;
            if (sum_ok) begin
               bus_id     <= byte_pick(id_word, ID_HI);
               tag_depth  <= DEPTH_BASE << byte_pick(tag_word, TAG_HI);
               active_neg <= byte_bit(mode_word, MODE_HI, NEG_BIT);
            end
         end
      end
   end
endmodule

// File: rtl/cfg_prom_loader.sv
module cfg_prom_loader #(
   parameter int unsigned SETTLE_CLKS = 8,
   parameter int unsigned WORD_CNT    = 64,
   parameter int unsigned WORD_W      = 16,
   parameter logic [7:0]  CMD_BASE    = 8'h80,
   parameter logic [15:0] SIGNATURE   = 16'h1234,
   parameter int unsigned ID_BYTE     = 'h40,
   parameter int unsigned MODE_BYTE   = 'h41,
   parameter int unsigned TAG_BYTE    = 'h43,
   parameter int unsigned NEG_BIT     = 3,
   parameter logic [7:0]  DEF_BUS_ID  = 8'd7,
   parameter int unsigned DEPTH_W     = 32,
   parameter bit          KEEP_IMAGE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   output logic               prom_cs,
   output logic               prom_sk,
   output logic               prom_do,
   input  logic               prom_di,
   output logic               load_done,
   output logic               cfg_valid,
   output logic [7:0]         cfg_bus_id,
   output logic [DEPTH_W-1:0] cfg_tag_depth,
   output logic               cfg_active_neg
);
   localparam int unsigned IDX_W      = $clog2(WORD_CNT);
   localparam int unsigned IMAGE_BYTES = 2 * WORD_CNT;

   generate
      if (SETTLE_CLKS < 1) begin : g_bad_settle
         $error("SETTLE_CLKS must be at least 1");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("field extraction assumes two bytes per word");
      end
      if (WORD_CNT < 2 || int'(CMD_BASE) + WORD_CNT > 256) begin : g_bad_cnt
         $error("word count must fit the 8-bit read opcode");
      end
      if (ID_BYTE >= IMAGE_BYTES || MODE_BYTE >= IMAGE_BYTES || TAG_BYTE >= IMAGE_BYTES) begin : g_bad_off
         $error("field offsets lie outside the image");
      end
      if (NEG_BIT > 7) begin : g_bad_bit
         $error("NEG_BIT must address a bit inside a byte");
      end
   endgenerate

   logic              tick, run, wr_en, finish;
   logic [IDX_W-1:0]  wr_idx;
   logic [WORD_W-1:0] wr_data;

   prom_tick_gen #(.SETTLE_CLKS(SETTLE_CLKS)) tick_i (
      .clk (clk), .rst (rst), .en (run), .tick (tick)
   );

   prom_word_reader #(
      .WORD_CNT (WORD_CNT), .WORD_W (WORD_W), .CMD_BASE (CMD_BASE)
   ) reader_i (
      .clk     (clk),     .rst     (rst),     .tick    (tick),   .run (run),
      .prom_cs (prom_cs), .prom_sk (prom_sk), .prom_do (prom_do),
      .prom_di (prom_di), .wr_en   (wr_en),   .wr_idx  (wr_idx),
      .wr_data (wr_data), .finish  (finish)
   );

   prom_image_store #(
      .WORD_CNT (WORD_CNT), .WORD_W (WORD_W), .SIGNATURE (SIGNATURE),
      .ID_BYTE (ID_BYTE), .MODE_BYTE (MODE_BYTE), .TAG_BYTE (TAG_BYTE),
      .NEG_BIT (NEG_BIT), .DEF_BUS_ID (DEF_BUS_ID), .DEPTH_W (DEPTH_W),
      .KEEP_IMAGE (KEEP_IMAGE)
   ) store_i (
      .clk (clk), .rst (rst), .wr_en (wr_en), .wr_idx (wr_idx),
      .wr_data (wr_data), .finish (finish), .done (load_done),
      .valid (cfg_valid), .bus_id (cfg_bus_id), .tag_depth (cfg_tag_depth),
      .active_neg (cfg_active_neg)
   );
endmodule

// File: rtl/cfg_prom_loader_chk.sv
module cfg_prom_loader_chk #(
   parameter int unsigned SETTLE_CLKS = 8,
   parameter logic [7:0]  DEF_BUS_ID  = 8'd7,
   parameter int unsigned DEPTH_W     = 32
) (
   input logic               clk,
   input logic               rst,
   input logic               prom_cs,
   input logic               prom_sk,
   input logic               prom_do,
   input logic               load_done,
   input logic               cfg_valid,
   input logic [7:0]         cfg_bus_id,
   input logic [DEPTH_W-1:0] cfg_tag_depth,
   input logic               cfg_active_neg
);
   logic [31:0] hi_run_q;
   logic        done_seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_run_q    <= '0;
         done_seen_q <= 1'b0;
      end else begin
         hi_run_q <= prom_sk ? hi_run_q + 1 : '0;
         if (load_done) done_seen_q <= 1'b1;
      end
   end

   // R2
   sk_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
      prom_sk |-> prom_cs);

   // R3
   do_steady_chk: assert property (@(posedge clk) disable iff (rst)
      (prom_sk && $past(prom_sk)) |-> $stable(prom_do));

   // R4
   sk_width_chk: assert property (@(posedge clk) disable iff (rst)
      (!prom_sk && $past(prom_sk)) |-> (hi_run_q == SETTLE_CLKS));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      load_done |-> !done_seen_q);

   // R6
   quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
      done_seen_q |-> (!prom_cs && !prom_sk));

   // R7
   valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_valid |=> cfg_valid);

   // R7
   valid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_valid) |-> load_done);

   // R11
   invalid_defaults_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_valid |-> (cfg_bus_id == DEF_BUS_ID && cfg_tag_depth == '0 && !cfg_active_neg));
endmodule

bind cfg_prom_loader cfg_prom_loader_chk #(
   .SETTLE_CLKS (SETTLE_CLKS), .DEF_BUS_ID (DEF_BUS_ID), .DEPTH_W (DEPTH_W)
) chk_i (
   .clk (clk), .rst (rst), .prom_cs (prom_cs), .prom_sk (prom_sk),
   .prom_do (prom_do), .load_done (load_done), .cfg_valid (cfg_valid),
   .cfg_bus_id (cfg_bus_id), .cfg_tag_depth (cfg_tag_depth),
   .cfg_active_neg (cfg_active_neg)
);

// File: tb/cfg_prom_loader_tb_top.sv
module cfg_prom_loader_tb_top;
   localparam int SETTLE    = 3;
   localparam int NWORDS    = 64;
   localparam int WATCHDOG  = 180000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        prom_di = 1'b0;
   logic        prom_cs, prom_sk, prom_do, load_done, cfg_valid, cfg_active_neg;
   logic [7:0]  cfg_bus_id;
   logic [31:0] cfg_tag_depth;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [15:0] img [NWORDS];

   // EEPROM model and protocol monitors
   int       edge_cnt = 0;
   logic [8:0] cmd_rx = '0;
   int       exp_word = 0;
   int       cmd_err = 0;
   int       width_err = 0;
   int       gap_err = 0;
   int       hi_run = 0;
   int       lo_run = 0;
   int       done_cycles = 0;
   int       model_idx;

   always #4 clk = ~clk;

   cfg_prom_loader #(.SETTLE_CLKS(SETTLE)) dut_i (
      .clk (clk), .rst (rst), .prom_cs (prom_cs), .prom_sk (prom_sk),
      .prom_do (prom_do), .prom_di (prom_di), .load_done (load_done),
      .cfg_valid (cfg_valid), .cfg_bus_id (cfg_bus_id),
      .cfg_tag_depth (cfg_tag_depth), .cfg_active_neg (cfg_active_neg)
   );

   always @(posedge prom_cs) begin
      edge_cnt = 0;
      cmd_rx   = '0;
   end

   always @(posedge prom_sk) begin
      if (prom_cs) begin
         if (edge_cnt < 9) begin
            cmd_rx = {cmd_rx[7:0], prom_do};
         end else if (edge_cnt < 25) begin
            model_idx = int'(cmd_rx[7:0]) - 128;
            if (model_idx >= 0 && model_idx < NWORDS)
               prom_di <= img[model_idx][15 - (edge_cnt - 9)];
            else
               prom_di <= 1'b0;
         end
         edge_cnt++;
      end
   end

   always @(negedge prom_cs) begin
      if (rst === 1'b0) begin
         if (edge_cnt != 25 || cmd_rx != {1'b1, 8'(128 + exp_word)}) cmd_err++;
         exp_word++;
      end
   end

   always @(negedge clk) begin
      if (rst) begin
         hi_run = 0;
         lo_run = 0;
      end else begin
         if (prom_sk) hi_run++;
         else begin
            if (hi_run != 0 && hi_run != SETTLE) width_err++;
            hi_run = 0;
         end
         if (prom_cs) begin
            if (lo_run != 0 && lo_run < SETTLE) gap_err++;
            lo_run = 0;
         end else lo_run++;
         if (load_done) done_cycles++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog: run hung actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] img_sum();
      logic [15:0] s = '0;
      for (int i = 0; i < NWORDS; i++) s += img[i];
      return s;
   endfunction

   task automatic build(input bit good, input bit rnd, input logic [7:0] id,
                        input logic [7:0] mode, input logic [7:0] tagx);
      logic [15:0] s;
      for (int i = 0; i < NWORDS; i++) img[i] = rnd ? 16'($urandom) : 16'h0;
      img[32] = {mode, id};
      img[33][15:8] = tagx;
      s = '0;
      for (int i = 0; i < NWORDS - 1; i++) s += img[i];
      img[NWORDS-1] = 16'h1234 - s + (good ? 16'h0 : 16'h1);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (4) @(negedge clk);
      // R1: reset values
      check(!prom_cs && !prom_sk && !prom_do, "R1", "pins in reset",
            {prom_cs, prom_sk, prom_do}, 0);
      check(!load_done && !cfg_valid && !cfg_active_neg && cfg_bus_id == 8'd7 &&
            cfg_tag_depth == 0, "R1", "outputs in reset",
            {cfg_bus_id, cfg_tag_depth}, {8'd7, 32'd0});
      exp_word = 0; cmd_err = 0; width_err = 0; gap_err = 0; done_cycles = 0;
      rst = 1'b0;
   endtask

   task automatic run_load(input string tag);
      logic [15:0] s;
      bit          ev;
      logic [7:0]  eid;
      logic [31:0] edep;
      logic        eneg;
      int          quiet_err;
      apply_reset();
      while (load_done !== 1'b1) @(negedge clk);
      s    = img_sum();
      ev   = (s == 16'h1234);
      eid  = ev ? img[32][7:0] : 8'd7;
      edep = ev ? (32'd2 << img[33][15:8]) : 32'd0;
      eneg = ev ? img[32][11] : 1'b0;
      check(exp_word == NWORDS, "R2", {tag, " transaction count"}, exp_word, NWORDS);
      check(cmd_err == 0, "R3", {tag, " command or edge mismatches"}, cmd_err, 0);
      check(width_err == 0 && gap_err == 0, "R4", {tag, " settle timing errors"},
            width_err + gap_err, 0);
      check(cfg_valid == ev, "R7", {tag, " valid flag"}, cfg_valid, ev);
      check(cfg_bus_id == eid, ev ? "R5 R8" : "R11", {tag, " bus id"}, cfg_bus_id, eid);
      check(cfg_tag_depth == edep, ev ? "R9" : "R11", {tag, " tag depth"}, cfg_tag_depth, edep);
      check(cfg_active_neg == eneg, ev ? "R10" : "R11", {tag, " active negation"},
            cfg_active_neg, eneg);
      quiet_err = 0;
      repeat (60) begin
         @(negedge clk);
         if (prom_cs || prom_sk || cfg_valid != ev) quiet_err++;
      end
      check(done_cycles == 1, "R6", {tag, " done pulse cycles"}, done_cycles, 1);
      check(quiet_err == 0, "R6", {tag, " activity after done"}, quiet_err, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1 at time zero
      repeat (3) @(negedge clk);
      check(!prom_cs && !load_done && cfg_bus_id == 8'd7, "R1", "initial reset state",
            {prom_cs, load_done, cfg_bus_id}, {1'b0, 1'b0, 8'd7});

      build(1'b1, 1'b1, 8'($urandom_range(0, 15)), 8'($urandom), 8'($urandom_range(0, 7)));
      run_load("random-good");

      build(1'b0, 1'b1, 8'h05, 8'h08, 8'h03);
      run_load("random-bad");

      // R9 top of the range, R10 bit set, asymmetric id for R5
      build(1'b1, 1'b1, 8'hB4, 8'h08, 8'd30);
      run_load("exp30");

      // R9 truncation, R10 bit clear with all others set
      build(1'b1, 1'b1, 8'hFF, 8'hF7, 8'd31);
      run_load("exp31");

      // all-zero image apart from the signature word
      build(1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
      run_load("zero-image");

      // R12: reset partway through, then a full load from word 0
      build(1'b1, 1'b1, 8'h3C, 8'h0A, 8'h04);
      apply_reset();
      while (exp_word < 5) @(negedge clk);
      check(!load_done && !cfg_valid, "R12", "no result mid-load",
            {load_done, cfg_valid}, 0);
      run_load("R12 restart");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule